// File: doc/BRIEF.md
# Split-Space Direct-Mapped Translation Buffer

This block caches virtual-to-physical page translations so that a processor does not repeat a page-table walk on every memory reference. A 32-bit virtual address is turned into a 30-bit physical address. Pages are 512 bytes, so the low nine address bits pass through unchanged and only the page number is looked up.

The storage is split into two equal, independently direct-mapped halves. One half holds system-space translations and the other holds process-space translations. The top virtual address bit chooses the half. When a lookup misses, the surrounding logic walks the page tables and writes the result through the fill port. On a context switch a single flush pulse drops every process-space translation and keeps the system-space entries.

The lookup result is registered and appears on the cycle after the request.

Top module: `xlate_buf`

## Requirements
- R1: After reset every entry is invalid, and `rsp_vld`, `rsp_hit` and `rsp_pa` are all zero.
- R2: `rsp_vld` is high in exactly the cycles that follow a cycle with `lk_req` high. When `rsp_vld` is low, `rsp_hit` and `rsp_pa` are zero.
- R3: A lookup hits when the entry it selects is valid and the stored tag equals `lk_va[30:18]`. The half is chosen by `lk_va[31]` (1 = system, 0 = process) and the index within the half by `lk_va[17:9]`. On a hit, `rsp_pa` = {stored page frame (21 bits), `lk_va[8:0]`}.
- R4: On a miss, `rsp_hit` is 0 and `rsp_pa` = {21 zero bits, `lk_va[8:0]`}.
- R5: Each page maps to one slot only. A fill with a different tag to an occupied slot replaces the earlier translation, so the earlier page then misses.
- R6: The two halves never alias. Addresses that differ only in bit 31 use separate entries.
- R7: A `flush_proc` pulse invalidates every process-half entry in that cycle. A lookup of the process half in the same cycle misses. System-half entries are unaffected.
- R8: When a fill and a lookup target the same slot in the same cycle, the lookup sees the filled entry.
- R9: Entries change only through the fill port. A lookup, hit or miss, never allocates or alters an entry.
- R10: A fill to the process half in the same cycle as `flush_proc` survives the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Write a translation |
| fill_va | input | 32 | Virtual address of the translation being written |
| fill_pfn | input | 21 | Physical page frame for the fill (PA bits 29..9) |
| flush_proc | input | 1 | Invalidate the process half |
| rsp_vld | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 30 | Translated physical address |

## Verification
The assertions assume that inputs change only away from the rising edge. They also assume that `fill_va` names the page whose walk produced `fill_pfn`, although the buffer itself never checks this. The bench drives every input on the falling edge and keeps the fill port consistent with its own page model. The randomized phase draws from a small set of tags and indexes, so slot conflicts, same-cycle fill and lookup collisions, and flushes that overlap fills all occur often. Directed steps first cover each collision case on its own.

// File: rtl/xlate_buf.sv
module xlate_buf #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFS_W = 9,
  parameter int IDX_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic [VA_W-1:0]          lk_va,
  input  logic                     fill_en,
  input  logic [VA_W-1:0]          fill_va,
  input  logic [PA_W-OFS_W-1:0]    fill_pfn,
  input  logic                     flush_proc,
  output logic                     rsp_vld,
  output logic                     rsp_hit,
  output logic [PA_W-1:0]          rsp_pa
);
  localparam int PFN_W  = PA_W - OFS_W;
  localparam int TAG_LO = OFS_W + IDX_W;
  localparam int TAG_W  = VA_W - 1 - TAG_LO;
  localparam int HALF   = 1 << IDX_W;
  localparam int SLOTS  = 2 * HALF;
  localparam int SLOT_W = IDX_W + 1;

  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [PFN_W-1:0] pfn_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  logic [SLOT_W-1:0] lk_slot, fill_slot;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  logic              same_slot, ent_v, hit_d;
  logic [TAG_W-1:0]  ent_tag;
  logic [PFN_W-1:0]  ent_pfn;

  assign lk_slot   = {lk_va[VA_W-1], lk_va[TAG_LO-1:OFS_W]};
  assign fill_slot = {fill_va[VA_W-1], fill_va[TAG_LO-1:OFS_W]};
  assign lk_tag    = lk_va[VA_W-2:TAG_LO];
  assign fill_tag  = fill_va[VA_W-2:TAG_LO];

  assign same_slot = fill_en && (fill_slot == lk_slot);
  assign ent_v     = same_slot ||
                     (vld_q[lk_slot] && !(flush_proc && !lk_va[VA_W-1]));
  assign ent_tag   = same_slot ? fill_tag : tag_q[lk_slot];
  assign ent_pfn   = same_slot ? fill_pfn : pfn_q[lk_slot];
  assign hit_d     = lk_req && ent_v && (ent_tag == lk_tag);

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_slot] <= fill_tag;
      pfn_q[fill_slot] <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (flush_proc) vld_q[HALF-1:0] <= '0;
      if (fill_en)    vld_q[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_pa  <= '0;
    end else begin
      rsp_vld <= lk_req;
      rsp_hit <= hit_d;
      rsp_pa  <= lk_req ? {(hit_d ? ent_pfn : {PFN_W{1'b0}}), lk_va[OFS_W-1:0]} : '0;
    end
  end

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_vld);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!rsp_hit && rsp_pa == '0));
  // R3
  ofs_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0]));
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !fill_en) |=> vld_q[HALF-1:0] == '0);
  // R7
  flush_sys_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_proc && !fill_en) |=> vld_q[SLOTS-1:HALF] == $past(vld_q[SLOTS-1:HALF]));
  // R8
  fill_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && fill_en && fill_va[VA_W-1:OFS_W] == lk_va[VA_W-1:OFS_W]) |=> rsp_hit);
  // R9
  no_lookup_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_en && !flush_proc) |=> vld_q == $past(vld_q));
endmodule

// File: tb/xlate_buf_tb_top.sv
module xlate_buf_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 1'b0, fill_en = 1'b0, flush_proc = 1'b0;
  logic [31:0] lk_va = '0, fill_va = '0;
  logic [20:0] fill_pfn = '0;
  logic rsp_vld, rsp_hit;
  logic [29:0] rsp_pa;

  always #10 clk = ~clk;

  xlate_buf dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
    .fill_en(fill_en), .fill_va(fill_va), .fill_pfn(fill_pfn),
    .flush_proc(flush_proc), .rsp_vld(rsp_vld), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa));

  typedef struct {
    int          due;
    bit          vld;
    bit          hit;
    logic [29:0] pa;
    string       rq;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit m_v [1024];
  logic [12:0] m_tag [1024];
  logic [20:0] m_pfn [1024];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(bit sys, logic [12:0] tag, logic [8:0] idx, logic [8:0] off);
    return {sys, tag, idx, off};
  endfunction

  task automatic step(bit req, logic [31:0] va, bit fe, logic [31:0] fva,
                      logic [20:0] pfn, bit fl, string rq);
    exp_t e;
    int s;
    lk_req = req; lk_va = va; fill_en = fe; fill_va = fva;
    fill_pfn = pfn; flush_proc = fl;
    if (fl) for (int i = 0; i < 512; i++) m_v[i] = 1'b0;
    if (fe) begin
      s = {fva[31], fva[17:9]};
      m_v[s] = 1'b1; m_tag[s] = fva[30:18]; m_pfn[s] = pfn;
    end
    s = {va[31], va[17:9]};
    e.due = cyc + 1;
    e.vld = req;
    e.hit = req && m_v[s] && (m_tag[s] == va[30:18]);
    e.pa  = req ? {(e.hit ? m_pfn[s] : 21'd0), va[8:0]} : 30'd0;
    e.rq  = (rq != "") ? rq : (e.hit ? "R3" : (req ? "R4" : "R2"));
    q.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      n_chk++;
      if (rsp_vld !== e.vld || rsp_hit !== e.hit || rsp_pa !== e.pa) begin
        n_fail++;
        $display("FAIL %s: got vld=%0b hit=%0b pa=%h, expected vld=%0b hit=%0b pa=%h",
                 e.rq, rsp_vld, rsp_hit, rsp_pa, e.vld, e.hit, e.pa);
      end
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    report();
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 1024; i++) m_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    n_chk++;
    if (rsp_vld !== 1'b0 || rsp_hit !== 1'b0 || rsp_pa !== '0) begin
      n_fail++;
      $display("FAIL R1: got vld=%0b hit=%0b pa=%h, expected 0 0 0", rsp_vld, rsp_hit, rsp_pa);
    end
    @(negedge clk);
    // R1: fresh buffer misses everywhere
    step(1, mk(1, 5, 3, 9'h01A), 0, 0, 0, 0, "R1");
    step(1, mk(0, 0, 0, 9'h000), 0, 0, 0, 0, "R1");
    // R2: fill without request gives no response
    step(0, 0, 1, mk(1, 5, 3, 0), 21'h12345, 0, "R2");
    step(1, mk(1, 5, 3, 9'h1FF), 0, 0, 0, 0, "R3");
    // R9: repeated misses allocate nothing
    step(1, mk(1, 7, 3, 9'h004), 0, 0, 0, 0, "R9");
    step(1, mk(1, 7, 3, 9'h004), 0, 0, 0, 0, "R9");
    // R6: halves kept apart
    step(0, 0, 1, mk(0, 5, 3, 0), 21'h0ABCD, 0, "R6");
    step(1, mk(0, 5, 3, 9'h033), 0, 0, 0, 0, "R6");
    step(1, mk(1, 5, 3, 9'h033), 0, 0, 0, 0, "R6");
    // R5: conflicting fill replaces
    step(0, 0, 1, mk(1, 9, 3, 0), 21'h11111, 0, "R5");
    step(1, mk(1, 5, 3, 9'h010), 0, 0, 0, 0, "R5");
    step(1, mk(1, 9, 3, 9'h010), 0, 0, 0, 0, "R5");
    // R8: same-cycle fill and lookup
    step(1, mk(1, 20, 40, 9'h055), 1, mk(1, 20, 40, 0), 21'h1F0F0, 0, "R8");
    step(1, mk(1, 21, 41, 9'h066), 1, mk(1, 22, 41, 0), 21'h02222, 0, "R8");
    step(1, mk(1, 22, 41, 9'h066), 0, 0, 0, 0, "R8");
    // R7: flush hits only the process half
    step(0, 0, 1, mk(0, 1, 10, 0), 21'h03333, 0, "R7");
    step(1, mk(0, 5, 3, 9'h001), 0, 0, 0, 1, "R7");
    step(1, mk(1, 9, 3, 9'h002), 0, 0, 0, 0, "R7");
    step(1, mk(0, 1, 10, 9'h003), 0, 0, 0, 0, "R7");
    // R10: fill survives a simultaneous flush
    step(0, 0, 1, mk(0, 2, 11, 0), 21'h04444, 1, "R10");
    step(1, mk(0, 2, 11, 9'h0AA), 0, 0, 0, 0, "R10");
    lcg = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = mk(lcg[31], {11'd0, lcg[1:0]}, {6'd0, lcg[4:2]}, lcg[13:5]);
      b = mk(lcg[30], {11'd0, lcg[15:14]}, {6'd0, lcg[18:16]}, 9'd0);
      step(lcg[20:19] != 2'b00, a, lcg[23:21] < 3'd3, b,
           {lcg[29:24], lcg[14:0]}, lcg[28:25] == 4'd0, "");
    end
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    report();
  end
endmodule